// File: doc/BRIEF.md
# Configurable TDM Audio Serial Transmitter

This block turns a stream of parallel PCM words into a single serial data line for an audio link. It runs as the timing master. A half-bit-period strobe from outside drives it, and from that strobe it builds the bit clock, the frame clock and the data line. Two framings are available. The first is a two-channel level framing, in which the frame clock holds one level per channel. The second is a pulse framing with up to eight time slots, in which a short sync pulse marks the start of each frame.

Static configuration inputs set the framing and the data layout. They cover the slot length in bit clocks, the sync pulse width, the delay from each slot start to its first data bit, the container size and the count of masked low bits, the bit order, the bit-clock edge on which data changes, and a mask that enables each slot. They also set how the line is released to high impedance. Configuration may only change while reset is held. Each enabled slot takes one sample from a valid/ready input, in slot order. A disabled slot takes no sample.

Top module: `tdm_tx`

## Requirements
- R1: After reset, and until the first launch edge, `sdata_o`, `sdata_oe`, `fclk_o` and `bclk_o` are 0 and `in_ready` is 1.
- R2: `bclk_o` toggles on every `half_tick`. With `cfg_edge_sel`=0, data and frame outputs change only when `bclk_o` rises. With `cfg_edge_sel`=1, they change only when it falls.
- R3: Level framing (`cfg_fmt`=0) has two slots of `cfg_chan_bits` bit clocks each. Slot 0 is the left channel. `fclk_o` equals the slot index XOR `cfg_lr_pol`, so with `cfg_lr_pol`=0 the left channel goes out while `fclk_o` is low.
- R4: In level framing with `cfg_nonsym`=1, slot 1 lasts `cfg_chan_bits`+1 bit clocks.
- R5: Pulse framing (`cfg_fmt`=1) has `cfg_last_slot`+1 slots of `cfg_chan_bits` bit clocks each. `fclk_o` is high for the first `cfg_fs_width`+1 bit clocks of slot 0 and low at all other times.
- R6: The first data bit of each slot falls at bit position `cfg_offset` within that slot, where position 0 is the first bit clock of the slot.
- R7: The sample length is 4*`cfg_size_code`+4-`cfg_mask_bits` bits, with a code from 1 to 7. Bit positions after the last sample bit drive 0.
- R8: With `cfg_lsb_first`=0, sample bit length-1 goes out first. With `cfg_lsb_first`=1, bit 0 goes out first.
- R9: Bit n of `cfg_slot_en` enables slot n. An enabled slot takes the oldest accepted sample. A disabled slot drives 0 and takes nothing. An enabled slot with no sample waiting drives 0 and takes nothing. The block holds one sample, and `in_ready` is high exactly when that holding place is empty.
- R10: With `cfg_hiz`=0, `sdata_oe` is 1 from the first launch edge onward.
- R11: With `cfg_hiz`=1, `sdata_oe` is 1 during enabled slots and 0 during disabled slots.
- R12: With `cfg_hiz`=2, `sdata_oe` rises at the launch edge of the first data bit. It falls at the non-launch edge that comes half a bit clock after the last data bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle strobe, once per half bit clock |
| cfg_fmt | input | 1 | 0 level framing, 1 pulse framing |
| cfg_lr_pol | input | 1 | Frame clock polarity in level framing |
| cfg_nonsym | input | 1 | Lengthen slot 1 by one bit in level framing |
| cfg_chan_bits | input | CNT_W | Bit clocks per slot, at least 1 |
| cfg_fs_width | input | FSW_W | Sync pulse width minus 1 |
| cfg_offset | input | CNT_W | Bit clocks from slot start to first data bit |
| cfg_size_code | input | 3 | Container size code, 1 to 7 |
| cfg_mask_bits | input | 3 | Low bits removed from the container |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_edge_sel | input | 1 | 0 data on rising, 1 on falling bit-clock edge |
| cfg_last_slot | input | SLOT_W | Slot count minus 1 in pulse framing |
| cfg_slot_en | input | MAX_SLOTS | Per-slot enable mask |
| cfg_hiz | input | 2 | Line release mode |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Holding place empty |
| in_data | input | SAMPLE_W | Sample, right-justified |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock or sync pulse |
| sdata_o | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for the data pad |

## Verification
The assertions assume that configuration stays constant outside reset and that `half_tick` never comes in two back-to-back cycles. They also assume that `cfg_chan_bits` is nonzero and that `cfg_size_code` is between 1 and 7. The stimulus sets every configuration field only while reset is held. It spaces the strobe three clocks apart and uses only legal codes, with slots long enough to show the offset and the trailing zero bits. When feeding is turned on, the feeder offers a new word as soon as `in_ready` returns. The model can then count on a sample waiting at every enabled slot start, except in the deliberate starvation run.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [0:0] {FMT_LEVEL = 1'b0, FMT_PULSE = 1'b1} frame_fmt_e;
  typedef enum logic [1:0] {HZ_DRIVE = 2'd0, HZ_SLOT = 2'd1, HZ_HALF = 2'd2} hiz_mode_e;

  function automatic logic [7:0] sample_len(input logic [2:0] code, input logic [2:0] mask);
    return {3'b000, code, 2'b00} + 8'd4 - {5'b00000, mask};
  endfunction
endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing import tdm_tx_pkg::*; #(
  parameter int CNT_W  = 11,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              edge_sel,
  input  logic              fmt,
  input  logic              nonsym,
  input  logic [CNT_W-1:0]  chan_bits,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              launch,
  output logic              mid,
  output logic              bclk,
  output logic [CNT_W-1:0]  pos_n,
  output logic [SLOT_W-1:0] slot_n,
  output logic              slot_start
);
  localparam logic [CNT_W:0] LEN_ONE = (CNT_W+1)'(1);

  logic              ph;
  logic              started;
  logic [CNT_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W:0]    slot_len;
  logic [SLOT_W-1:0] top_slot;
  logic              level;

  assign level  = (frame_fmt_e'(fmt) == FMT_LEVEL);
  assign launch = half_tick && (ph == edge_sel);
  assign mid    = half_tick && (ph != edge_sel);
  assign bclk   = ph;
  assign slot_start = launch && (pos_n == '0);

  always_comb begin
    slot_len = {1'b0, chan_bits} + ((level && nonsym && slot == SLOT_W'(1)) ? LEN_ONE : '0);
    top_slot = level ? SLOT_W'(1) : last_slot;
    if (!started) begin
      pos_n  = '0;
      slot_n = '0;
    end else if (({1'b0, pos} + LEN_ONE) >= slot_len) begin
      pos_n  = '0;
      slot_n = (slot >= top_slot) ? '0 : slot + SLOT_W'(1);
    end else begin
      pos_n  = pos + CNT_W'(1);
      slot_n = slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      started <= 1'b0;
      pos     <= '0;
      slot    <= '0;
    end else begin
      if (half_tick) ph <= ~ph;
      if (launch) begin
        started <= 1'b1;
        pos     <= pos_n;
        slot    <= slot_n;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_feed.sv
module tdm_tx_feed #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic                consume,
  output logic [SAMPLE_W-1:0] take_data
);
  logic                full;
  logic [SAMPLE_W-1:0] hold;

  assign in_ready  = !full;
  assign take_data = full ? hold : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      hold <= in_data;
    end else if (consume) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_tx_serial.sv
module tdm_tx_serial import tdm_tx_pkg::*; #(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 11,
  parameter int SLOT_W   = 3,
  parameter int FSW_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic                mid,
  input  logic                slot_start,
  input  logic                slot_on,
  input  logic [CNT_W-1:0]    pos_n,
  input  logic [SLOT_W-1:0]   slot_n,
  input  logic                fmt,
  input  logic                lr_pol,
  input  logic [FSW_W-1:0]    fs_width,
  input  logic [CNT_W-1:0]    offset,
  input  logic [2:0]          size_code,
  input  logic [2:0]          mask_bits,
  input  logic                lsb_first,
  input  logic [1:0]          hiz,
  input  logic [SAMPLE_W-1:0] take_data,
  output logic                sdata,
  output logic                oe,
  output logic                fclk
);
  logic [SAMPLE_W-1:0] smp;
  logic [SAMPLE_W-1:0] cur;
  logic [CNT_W-1:0]    len;
  logic [CNT_W-1:0]    k;
  logic [CNT_W-1:0]    idx;
  logic                is_data;
  logic                bit_val;
  logic                fclk_n;
  logic                drive;

  always_comb begin
    cur     = slot_start ? (slot_on ? take_data : '0) : smp;
    len     = CNT_W'(sample_len(size_code, mask_bits));
    k       = pos_n - offset;
    is_data = slot_on && (pos_n >= offset) && (k < len);
    idx     = lsb_first ? k : (len - CNT_W'(1) - k);
    bit_val = |(cur & (SAMPLE_W'(1) << idx));
    if (frame_fmt_e'(fmt) == FMT_LEVEL) fclk_n = slot_n[0] ^ lr_pol;
    else fclk_n = (slot_n == '0) && (pos_n <= CNT_W'(fs_width));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= '0;
      sdata <= 1'b0;
      oe    <= 1'b0;
      fclk  <= 1'b0;
      drive <= 1'b0;
    end else if (launch) begin
      smp   <= cur;
      sdata <= is_data && bit_val;
      fclk  <= fclk_n;
      drive <= is_data;
      case (hiz_mode_e'(hiz))
        HZ_SLOT: oe <= slot_on;
        HZ_HALF: if (is_data) oe <= 1'b1;
        default: oe <= 1'b1;
      endcase
    end else if (mid && hiz_mode_e'(hiz) == HZ_HALF && !drive) begin
      oe <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int SAMPLE_W  = 32,
  parameter int CNT_W     = 11,
  parameter int FSW_W     = 8,
  parameter int MAX_SLOTS = 8,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 half_tick,
  input  logic                 cfg_fmt,
  input  logic                 cfg_lr_pol,
  input  logic                 cfg_nonsym,
  input  logic [CNT_W-1:0]     cfg_chan_bits,
  input  logic [FSW_W-1:0]     cfg_fs_width,
  input  logic [CNT_W-1:0]     cfg_offset,
  input  logic [2:0]           cfg_size_code,
  input  logic [2:0]           cfg_mask_bits,
  input  logic                 cfg_lsb_first,
  input  logic                 cfg_edge_sel,
  input  logic [SLOT_W-1:0]    cfg_last_slot,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en,
  input  logic [1:0]           cfg_hiz,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  in_data,
  output logic                 bclk_o,
  output logic                 fclk_o,
  output logic                 sdata_o,
  output logic                 sdata_oe
);
  logic                launch, mid, slot_start, slot_on, consume;
  logic [CNT_W-1:0]    pos_n;
  logic [SLOT_W-1:0]   slot_n;
  logic [SAMPLE_W-1:0] take_data;

  assign slot_on = cfg_slot_en[slot_n];
  assign consume = slot_start && slot_on;

  tdm_tx_timing #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) i_timing (
    .clk(clk), .rst(rst), .half_tick(half_tick), .edge_sel(cfg_edge_sel),
    .fmt(cfg_fmt), .nonsym(cfg_nonsym), .chan_bits(cfg_chan_bits),
    .last_slot(cfg_last_slot), .launch(launch), .mid(mid), .bclk(bclk_o),
    .pos_n(pos_n), .slot_n(slot_n), .slot_start(slot_start)
  );

  tdm_tx_feed #(.SAMPLE_W(SAMPLE_W)) i_feed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .consume(consume), .take_data(take_data)
  );

  tdm_tx_serial #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W), .FSW_W(FSW_W)) i_serial (
    .clk(clk), .rst(rst), .launch(launch), .mid(mid), .slot_start(slot_start),
    .slot_on(slot_on), .pos_n(pos_n), .slot_n(slot_n), .fmt(cfg_fmt),
    .lr_pol(cfg_lr_pol), .fs_width(cfg_fs_width), .offset(cfg_offset),
    .size_code(cfg_size_code), .mask_bits(cfg_mask_bits), .lsb_first(cfg_lsb_first),
    .hiz(cfg_hiz), .take_data(take_data), .sdata(sdata_o), .oe(sdata_oe), .fclk(fclk_o)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       half_tick,
  input logic       edge_sel,
  input logic [1:0] hiz,
  input logic       in_valid,
  input logic       in_ready,
  input logic       bclk,
  input logic       fclk,
  input logic       sdata,
  input logic       oe
);
  a_r2_bclk_toggle: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> (bclk != $past(bclk)));

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> ($stable(bclk) && $stable(sdata) && $stable(fclk) && $stable(oe)));

  a_r2_no_change_off_edge: assert property (@(posedge clk) disable iff (rst)
    (half_tick && bclk != edge_sel) |=> ($stable(sdata) && $stable(fclk)));

  a_r9_one_sample_held: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r10_keep_driving: assert property (@(posedge clk) disable iff (rst)
    (hiz == 2'd0 && oe) |=> oe);

  a_r12_no_rise_mid_bit: assert property (@(posedge clk) disable iff (rst)
    (hiz == 2'd2 && half_tick && bclk != edge_sel) |=> !(oe && !$past(oe)));
endmodule

bind tdm_tx tdm_tx_chk i_chk (
  .clk(clk), .rst(rst), .half_tick(half_tick), .edge_sel(cfg_edge_sel),
  .hiz(cfg_hiz), .in_valid(in_valid), .in_ready(in_ready), .bclk(bclk_o),
  .fclk(fclk_o), .sdata(sdata_o), .oe(sdata_oe)
);

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  localparam int W = 32;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0;
  logic cfg_fmt = 0, cfg_lr_pol = 0, cfg_nonsym = 0, cfg_lsb_first = 0, cfg_edge_sel = 0;
  logic [CW-1:0] cfg_chan_bits = 11'd16, cfg_offset = '0;
  logic [7:0] cfg_fs_width = '0, cfg_slot_en = 8'h03;
  logic [2:0] cfg_size_code = 3'd3, cfg_mask_bits = '0, cfg_last_slot = '0;
  logic [1:0] cfg_hiz = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, bclk_o, fclk_o, sdata_o, sdata_oe;

  tdm_tx i_tdm_tx (
    .clk(clk), .rst(rst), .half_tick(half_tick), .cfg_fmt(cfg_fmt), .cfg_lr_pol(cfg_lr_pol),
    .cfg_nonsym(cfg_nonsym), .cfg_chan_bits(cfg_chan_bits), .cfg_fs_width(cfg_fs_width),
    .cfg_offset(cfg_offset), .cfg_size_code(cfg_size_code), .cfg_mask_bits(cfg_mask_bits),
    .cfg_lsb_first(cfg_lsb_first), .cfg_edge_sel(cfg_edge_sel), .cfg_last_slot(cfg_last_slot),
    .cfg_slot_en(cfg_slot_en), .cfg_hiz(cfg_hiz), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, seq = 0, launch_cnt = 0, tick_cnt = 0;
  bit tick_on = 0, feed_on = 0, mon_on = 0, done = 0;
  logic [W-1:0] q[$];
  bit mph, mstarted, mdrive, exp_oe;
  int mpos, mslot;
  logic [W-1:0] msmp;
  string dtag = "R6", ftag = "R3", otag = "R10";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (tick_on) begin
      tick_cnt++;
      half_tick = (tick_cnt % 3 == 0);
    end else half_tick = 1'b0;
  end

  initial forever begin
    @(negedge clk);
    if (feed_on) begin
      in_valid = 1'b1;
      in_data = 32'h9E37_79B9 * (seq + 1) ^ 32'h5A5A_0F0F;
      @(posedge clk);
      if (in_ready) begin
        q.push_back(in_data);
        seq++;
      end
    end else in_valid = 1'b0;
  end

  task automatic step();
    int len, l, k, top;
    bit en, isd, b, fexp;
    if (mph == cfg_edge_sel) begin
      mph = ~mph;
      launch_cnt++;
      if (!mstarted) begin
        mstarted = 1; mpos = 0; mslot = 0;
      end else begin
        len = int'(cfg_chan_bits) + ((cfg_fmt == 0 && cfg_nonsym && mslot == 1) ? 1 : 0);
        top = (cfg_fmt == 0) ? 1 : int'(cfg_last_slot);
        if (mpos == len - 1) begin
          mpos = 0;
          mslot = (mslot == top) ? 0 : mslot + 1;
        end else mpos++;
      end
      en = cfg_slot_en[mslot];
      if (mpos == 0) begin
        if (en && q.size() > 0) msmp = q.pop_front();
        else msmp = '0;
      end
      l = 4 * int'(cfg_size_code) + 4 - int'(cfg_mask_bits);
      k = mpos - int'(cfg_offset);
      isd = en && (mpos >= int'(cfg_offset)) && (k < l);
      b = isd ? msmp[cfg_lsb_first ? k : l - 1 - k] : 1'b0;
      if (cfg_fmt == 0) fexp = mslot[0] ^ cfg_lr_pol;
      else fexp = (mslot == 0) && (mpos <= int'(cfg_fs_width));
      case (cfg_hiz)
        2'd0: exp_oe = 1;
        2'd1: exp_oe = en;
        default: if (isd) exp_oe = 1;
      endcase
      mdrive = isd;
      chk("R2 bclk at launch", bclk_o, !cfg_edge_sel);
      chk(en ? dtag : "R9 disabled slot", sdata_o, b);
      chk(ftag, fclk_o, fexp);
      chk(otag, sdata_oe, exp_oe);
    end else begin
      mph = ~mph;
      if (cfg_hiz == 2'd2 && !mdrive) exp_oe = 0;
      chk("R2 bclk at mid", bclk_o, cfg_edge_sel);
      if (cfg_hiz == 2'd2) chk("R12 release", sdata_oe, exp_oe);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (half_tick && !rst && mon_on) begin
      @(negedge clk);
      step();
    end
  end

  task automatic setup(input bit fmt, input bit pol, input bit nsym, input int chan,
                       input int fsw, input int off, input int code, input int mask,
                       input bit lsb, input bit edg, input int last, input int en,
                       input int hz, input bit feed, input string dt, input string ft,
                       input string ot);
    tick_on = 0; feed_on = 0; mon_on = 0;
    repeat (4) @(negedge clk);
    cfg_fmt = fmt; cfg_lr_pol = pol; cfg_nonsym = nsym; cfg_chan_bits = CW'(chan);
    cfg_fs_width = 8'(fsw); cfg_offset = CW'(off); cfg_size_code = 3'(code);
    cfg_mask_bits = 3'(mask); cfg_lsb_first = lsb; cfg_edge_sel = edg;
    cfg_last_slot = 3'(last); cfg_slot_en = 8'(en); cfg_hiz = 2'(hz);
    dtag = dt; ftag = ft; otag = ot;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    q.delete();
    mph = 0; mstarted = 0; mdrive = 0; exp_oe = 0; mpos = 0; mslot = 0; msmp = '0;
    launch_cnt = 0;
    @(negedge clk);
    chk("R1 sdata", sdata_o, 0);
    chk("R1 oe", sdata_oe, 0);
    chk("R1 fclk", fclk_o, 0);
    chk("R1 bclk", bclk_o, 0);
    chk("R1 ready", in_ready, 1);
    feed_on = feed;
    repeat (4) @(negedge clk);
    mon_on = 1; tick_on = 1;
  endtask

  task automatic run_bits(input int n);
    while (launch_cnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (200) @(negedge clk);
    // level framing, 16-bit, offset 1, MSB first, always driven: R3 R6 R10
    setup(0, 0, 0, 16, 0, 1, 3, 0, 0, 0, 0, 8'h03, 0, 1, "R6", "R3", "R10");
    run_bits(160);
    // non-symmetric level, inverted polarity, 10-bit LSB first, slot 1 off: R4 R8 R11
    setup(0, 1, 1, 20, 0, 0, 2, 2, 1, 1, 0, 8'h01, 1, 1, "R8", "R4", "R11");
    run_bits(205);
    // four-slot pulse framing, 8-bit, offset 2, slot 2 off, half-bit release: R5 R7 R12
    setup(1, 0, 0, 12, 2, 2, 1, 0, 0, 0, 3, 8'h0B, 2, 1, "R7", "R5", "R12");
    run_bits(192);
    // eight-slot pulse framing, one-bit sync, falling edge launch: R5 R9
    setup(1, 0, 0, 8, 0, 0, 1, 0, 0, 1, 7, 8'hFF, 0, 1, "R9", "R5", "R10");
    run_bits(256);
    // starved input: enabled slots send zeros: R9
    setup(0, 0, 0, 16, 0, 0, 3, 0, 0, 0, 0, 8'h03, 0, 0, "R9", "R3", "R10");
    run_bits(96);
    chk("R9 ready while starved", in_ready, 1);
    tick_on = 0; mon_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule